// File: doc/BRIEF.md
# Halt-state fetch cycle sequencer

This block is the halt portion of the bus sequencer of a small 8-bit processor. Every machine cycle is an opcode fetch of four clock states. In the first two states the fetch, memory-request and read strobes are active and the program counter is on the address bus. In the last two states the refresh strobe is active and a 7-bit refresh counter is on the address bus. When the core asks to halt, the sequencer does not stop the clock. It keeps running these fetch cycles, so dynamic memory refresh goes on. It throws away the byte on the data bus and loads a no-operation code into the instruction register instead. A halt acknowledge output stays high for the whole time.

The two interrupt inputs are examined on one clock edge per machine cycle: the edge that begins the fourth state. A non-maskable request is caught on its rising edge and held as pending until it is acknowledged. A maskable request is a level, and it counts only while the interrupt-enable flag is set. If a sample qualifies, halt ends at the edge that closes that machine cycle. A one-clock start pulse then marks the first state of the following acknowledge cycle, with a code for its kind. The non-maskable kind wins when both are present.

Top module: `halt_fetch_seq`

## Requirements
- R1: Every machine cycle has four states, T1 to T4. In T1 and T2, `fetch_o`, `rd_o` and `mreq_o` are 1, `rfsh_o` is 0 and `addr_o` equals `pc_i`. In T3, `rfsh_o` and `mreq_o` are 1. In T4, only `rfsh_o` is 1. In T3 and T4, `addr_o` carries the refresh counter in bits 7:0 and zeros above. After reset is released, the first cycle is T1.
- R2: `halt_req` is looked at only on the edge that ends T4. If it is 1 there, `halt_ack_o` is 1 from the next T1. It then stays 1 until an acknowledge starts. A pulse of `halt_req` that does not cover that edge has no effect.
- R3: The instruction register `opcode_o` is loaded on the edge that ends T2. In a halted cycle it is loaded with 8'h00 (no-operation) whatever `data_i` holds. In a running cycle it is loaded with `data_i`.
- R4: The low 7 bits of the refresh counter go up by one on the edge that ends each T4, halted or not, and wrap from 127 to 0. Bit 7 keeps its reset value 0.
- R5: The interrupt inputs are sampled only on the edge that begins T4. A maskable request that is high only outside that edge does not end halt.
- R6: After a qualifying sample, the edge that ends that T4 clears `halt_ack_o` and raises `ack_start_o` for exactly one clock, during the next T1. While `ack_start_o` is 1, `ack_type_o` is 2'b01 for non-maskable and 2'b10 for maskable. Otherwise it is 2'b00.
- R7: The interrupt-enable flag is loaded from `ie_value` on a clock where `ie_load` is 1. While the flag is clear, a maskable request has no effect.
- R8: A rising edge on `nmi_req` is latched as pending even if the pulse lasts one clock. A non-maskable request held high gives one acknowledge only. The pending flag is cleared by its acknowledge.
- R9: If both kinds qualify at the same sample, the acknowledge type is non-maskable.
- R10: A non-maskable acknowledge clears the interrupt-enable flag. A maskable acknowledge leaves the flag set.
- R11: A synchronous active-high `rst` clears halt, the enable flag, the pending non-maskable flag, the refresh counter and the instruction register, and restarts the cycle at T1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| halt_req | input | 1 | Core request to enter the halted loop |
| nmi_req | input | 1 | Non-maskable interrupt request, rising-edge sensitive |
| int_req | input | 1 | Maskable interrupt request, level sensitive |
| ie_load | input | 1 | Load strobe for the interrupt-enable flag |
| ie_value | input | 1 | Value loaded into the interrupt-enable flag |
| pc_i | input | 16 | Fetch address supplied by the core |
| data_i | input | 8 | Byte returned by memory during a fetch |
| addr_o | output | 16 | Address bus: fetch address or refresh address |
| fetch_o | output | 1 | Opcode-fetch strobe (T1 to T2) |
| mreq_o | output | 1 | Memory request (T1 to T3) |
| rd_o | output | 1 | Memory read (T1 to T2) |
| rfsh_o | output | 1 | Refresh strobe (T3 to T4) |
| halt_ack_o | output | 1 | High while halted |
| opcode_o | output | 8 | Instruction register |
| ack_start_o | output | 1 | One-clock pulse starting the acknowledge cycle |
| ack_type_o | output | 2 | Acknowledge kind: 01 non-maskable, 10 maskable, 00 none |

## Verification
The assertions check rules that hold in every cycle. The read and refresh strobes never overlap. Halt starts only after a request, and it ends only together with an acknowledge pulse. That pulse is one clock long, comes in a T1 right after a halted T4, and carries a legal type code. A halted cycle never holds anything but the no-operation code in T3 and T4. Other behaviour depends on what happened earlier, and only the bench scenarios can show it. This covers the sampling window, the masking by the enable flag, the single acknowledge for a held non-maskable line, priority, the enable flag cleared after a non-maskable acknowledge, the refresh wrap and the effect of reset in the middle of a halt. The bench checks these against the exact cycle in which each acknowledge is due.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

    typedef enum logic [1:0] {
        ST_T1 = 2'd0,
        ST_T2 = 2'd1,
        ST_T3 = 2'd2,
        ST_T4 = 2'd3
    } tstate_e;

    localparam logic [1:0] ACK_NONE = 2'b00;
    localparam logic [1:0] ACK_NMI  = 2'b01;
    localparam logic [1:0] ACK_INT  = 2'b10;

endpackage

// File: rtl/hfs_tstate.sv
module hfs_tstate
    import hfs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    output tstate_e tstate_o,
    output logic    sample_edge_o,
    output logic    cycle_end_o
);

    tstate_e t_d, t_q;

    always_comb begin
        unique case (t_q)
            ST_T1:   t_d = ST_T2;
            ST_T2:   t_d = ST_T3;
            ST_T3:   t_d = ST_T4;
            default: t_d = ST_T1;
        endcase
        if (rst) begin
            t_d = ST_T1;
        end
    end

    always_ff @(posedge clk) begin
        t_q <= t_d;
    end

    assign tstate_o      = t_q;
    assign sample_edge_o = (t_q == ST_T3);
    assign cycle_end_o   = (t_q == ST_T4);

endmodule

// File: rtl/hfs_refresh.sv
module hfs_refresh #(
    parameter int CNT_W = 8,
    parameter int LOW_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [LOW_W-1:0] low_next;

    assign low_next = cnt_q[LOW_W-1:0] + 1'b1;

    generate
        if (CNT_W > LOW_W) begin : g_held_top
            always_comb begin
                cnt_d = cnt_q;
                if (step_i) begin
                    cnt_d = {cnt_q[CNT_W-1:LOW_W], low_next};
                end
                if (rst) begin
                    cnt_d = '0;
                end
            end
        end else begin : g_low_only
            always_comb begin
                cnt_d = cnt_q;
                if (step_i) begin
                    cnt_d = low_next;
                end
                if (rst) begin
                    cnt_d = '0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/hfs_irq.sv
module hfs_irq (
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic int_req,
    input  logic ie_i,
    input  logic sample_i,
    input  logic nmi_clear_i,
    output logic nmi_seen_o,
    output logic int_seen_o
);

    typedef struct packed {
        logic nmi_prev;
        logic nmi_pend;
        logic nmi_seen;
        logic int_seen;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    nmi_rise;

    assign nmi_rise = nmi_req & ~st_q.nmi_prev;

    always_comb begin
        st_d          = st_q;
        st_d.nmi_prev = nmi_req;
        st_d.nmi_pend = (st_q.nmi_pend & ~nmi_clear_i) | nmi_rise;
        if (sample_i) begin
            st_d.nmi_seen = st_q.nmi_pend;
            st_d.int_seen = int_req & ie_i;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign nmi_seen_o = st_q.nmi_seen;
    assign int_seen_o = st_q.int_seen;

endmodule

// File: rtl/halt_fetch_seq.sv
module halt_fetch_seq
    import hfs_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          RFSH_W   = 8,
    parameter int          RFSH_LOW = 7,
    parameter logic [7:0]  NOP_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halt_req,
    input  logic              nmi_req,
    input  logic              int_req,
    input  logic              ie_load,
    input  logic              ie_value,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              fetch_o,
    output logic              mreq_o,
    output logic              rd_o,
    output logic              rfsh_o,
    output logic              halt_ack_o,
    output logic [DATA_W-1:0] opcode_o,
    output logic              ack_start_o,
    output logic [1:0]        ack_type_o
);

    localparam int PAD_W = ADDR_W - RFSH_W;
    localparam logic [DATA_W-1:0] NOP_W = DATA_W'(NOP_CODE);

    typedef struct packed {
        logic              halt;
        logic              ie;
        logic              ack_start;
        logic [1:0]        ack_type;
        logic [DATA_W-1:0] opcode;
    } seq_st_t;

    seq_st_t          st_d, st_q;
    tstate_e          tst;
    logic             sample_edge;
    logic             cycle_end;
    logic             nmi_seen;
    logic             int_seen;
    logic             nmi_clear;
    logic             fetch_phase;
    logic [RFSH_W-1:0] rfsh_cnt;

    hfs_tstate u_tstate (
        .clk           (clk),
        .rst           (rst),
        .tstate_o      (tst),
        .sample_edge_o (sample_edge),
        .cycle_end_o   (cycle_end)
    );

    hfs_refresh #(
        .CNT_W (RFSH_W),
        .LOW_W (RFSH_LOW)
    ) u_refresh (
        .clk     (clk),
        .rst     (rst),
        .step_i  (cycle_end),
        .count_o (rfsh_cnt)
    );

    hfs_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .nmi_req     (nmi_req),
        .int_req     (int_req),
        .ie_i        (st_q.ie),
        .sample_i    (sample_edge),
        .nmi_clear_i (nmi_clear),
        .nmi_seen_o  (nmi_seen),
        .int_seen_o  (int_seen)
    );

    // Non-maskable acknowledge begins at the close of a halted T4
    assign nmi_clear = cycle_end & st_q.halt & nmi_seen;

    always_comb begin
        st_d           = st_q;
        st_d.ack_start = 1'b0;
        st_d.ack_type  = ACK_NONE;

        if (ie_load) begin
            st_d.ie = ie_value;
        end

        // Instruction register loads at the close of T2
        if (tst == ST_T2) begin
            st_d.opcode = st_q.halt ? NOP_W : data_i;
        end

        if (cycle_end) begin
            if (st_q.halt) begin
                if (nmi_seen) begin
                    st_d.halt      = 1'b0;
                    st_d.ie        = 1'b0;
                    st_d.ack_start = 1'b1;
                    st_d.ack_type  = ACK_NMI;
                end else if (int_seen) begin
                    st_d.halt      = 1'b0;
                    st_d.ack_start = 1'b1;
                    st_d.ack_type  = ACK_INT;
                end
            end else if (halt_req) begin
                st_d.halt = 1'b1;
            end
        end

        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_phase = (tst == ST_T1) || (tst == ST_T2);
    assign fetch_o     = fetch_phase;
    assign rd_o        = fetch_phase;
    assign mreq_o      = (tst != ST_T4);
    assign rfsh_o      = ~fetch_phase;
    assign addr_o      = fetch_phase ? pc_i : {{PAD_W{1'b0}}, rfsh_cnt};
    assign halt_ack_o  = st_q.halt;
    assign opcode_o    = st_q.opcode;
    assign ack_start_o = st_q.ack_start;
    assign ack_type_o  = st_q.ack_type;

endmodule

// File: rtl/hfs_chk.sv
module hfs_chk #(
    parameter int         DATA_W   = 8,
    parameter logic [7:0] NOP_CODE = 8'h00
) (
    input logic              clk,
    input logic              rst,
    input logic              halt_req,
    input logic              fetch_o,
    input logic              mreq_o,
    input logic              rd_o,
    input logic              rfsh_o,
    input logic              halt_ack_o,
    input logic [DATA_W-1:0] opcode_o,
    input logic              ack_start_o,
    input logic [1:0]        ack_type_o
);

    AST_RD_NOT_RFSH: assert property (@(posedge clk) disable iff (rst)
        rd_o |-> !rfsh_o); // R1

    AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_ack_o) |-> ($past(halt_req) && fetch_o)); // R2

    AST_HALT_EXIT_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        ($fell(halt_ack_o) && !$past(rst)) |-> ack_start_o); // R2

    AST_NOP_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
        (halt_ack_o && rfsh_o) |-> (opcode_o == DATA_W'(NOP_CODE))); // R3

    AST_ACK_AFTER_HALTED_T4: assert property (@(posedge clk) disable iff (rst)
        ack_start_o |-> (fetch_o && $past(rfsh_o && !mreq_o) && $past(halt_ack_o))); // R6

    AST_ACK_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        ack_start_o |=> !ack_start_o); // R6

    AST_ACK_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        ack_start_o |-> (ack_type_o == 2'b01 || ack_type_o == 2'b10)); // R6

    AST_NO_CODE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !ack_start_o |-> (ack_type_o == 2'b00)); // R6

endmodule

bind halt_fetch_seq hfs_chk #(
    .DATA_W   (DATA_W),
    .NOP_CODE (NOP_CODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt_req    (halt_req),
    .fetch_o     (fetch_o),
    .mreq_o      (mreq_o),
    .rd_o        (rd_o),
    .rfsh_o      (rfsh_o),
    .halt_ack_o  (halt_ack_o),
    .opcode_o    (opcode_o),
    .ack_start_o (ack_start_o),
    .ack_type_o  (ack_type_o)
);

// File: tb/sim_halt_fetch_seq.sv
`timescale 1ns/1ps
module sim_halt_fetch_seq;

    localparam logic [15:0] PC_VAL = 16'h1234;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic        int_req = 1'b0;
    logic        ie_load = 1'b0;
    logic        ie_value = 1'b0;
    logic [15:0] pc_i = PC_VAL;
    logic [7:0]  data_i = 8'h00;
    logic [15:0] addr_o;
    logic        fetch_o, mreq_o, rd_o, rfsh_o, halt_ack_o;
    logic [7:0]  opcode_o;
    logic        ack_start_o;
    logic [1:0]  ack_type_o;

    halt_fetch_seq u0 (
        .clk         (clk),
        .rst         (rst),
        .halt_req    (halt_req),
        .nmi_req     (nmi_req),
        .int_req     (int_req),
        .ie_load     (ie_load),
        .ie_value    (ie_value),
        .pc_i        (pc_i),
        .data_i      (data_i),
        .addr_o      (addr_o),
        .fetch_o     (fetch_o),
        .mreq_o      (mreq_o),
        .rd_o        (rd_o),
        .rfsh_o      (rfsh_o),
        .halt_ack_o  (halt_ack_o),
        .opcode_o    (opcode_o),
        .ack_start_o (ack_start_o),
        .ack_type_o  (ack_type_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [1:0]  ty;
        int unsigned at;
    } exp_t;

    exp_t        expq[$];
    int          checks = 0;
    int          errors = 0;
    int unsigned cyc = 0;
    logic        live = 1'b0;
    logic [6:0]  exp_rf = 7'd0;
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Clocks since reset release; phase = cyc % 4 (0=T1 .. 3=T4)
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
        live <= !rst;
    end

    // Monitor: bus pattern, refresh model, acknowledge scoreboard
    always @(negedge clk) begin
        if (!live) begin
            exp_rf <= 7'd0;
        end else begin
            automatic int ph = int'(cyc % 4);
            automatic bit fe = (ph < 2);
            chk(fetch_o == fe && rd_o == fe && rfsh_o == !fe && mreq_o == (ph != 3),
                "R1 strobes", {fetch_o, rd_o, mreq_o, rfsh_o}, {fe, fe, ph != 3, !fe});
            if (fe) begin
                chk(addr_o == PC_VAL, "R1 fetch address", addr_o, PC_VAL);
            end else begin
                chk(addr_o == {9'd0, exp_rf}, "R4 refresh address", addr_o, {9'd0, exp_rf});
            end
            if (ph == 3) exp_rf <= exp_rf + 7'd1;
            if (expq.size() > 0 && expq[0].at < cyc) begin
                chk(1'b0, "R6 missing acknowledge", 0, expq[0].at);
                void'(expq.pop_front());
            end
            if (ack_start_o) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 unexpected acknowledge", ack_type_o, 0);
                end else begin
                    automatic exp_t e = expq.pop_front();
                    chk(e.at == cyc, "R6 acknowledge cycle", cyc, e.at);
                    chk(e.ty == ack_type_o, "R6 acknowledge type", ack_type_o, e.ty);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic goto(input int p);
        do tick(); while (int'(cyc % 4) != p);
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) goto(0);
    endtask

    task automatic expect_ack(input logic [1:0] ty, input int unsigned at);
        exp_t e;
        e.ty = ty;
        e.at = at;
        expq.push_back(e);
    endtask

    task automatic enter_halt();
        goto(3);
        halt_req = 1'b1;
        tick();
        halt_req = 1'b0;
        chk(halt_ack_o == 1'b1, "R2 halt entry", halt_ack_o, 1);
    endtask

    task automatic set_ie(input logic v);
        ie_load  = 1'b1;
        ie_value = v;
        tick();
        ie_load  = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned k;
        repeat (3) tick();
        rst = 1'b0;
        // R11: state right after reset
        chk(halt_ack_o == 1'b0 && ack_start_o == 1'b0, "R11 idle after reset",
            {halt_ack_o, ack_start_o}, 0);
        chk(fetch_o == 1'b1 && addr_o == PC_VAL, "R11 starts at T1", fetch_o, 1);
        chk(opcode_o == 8'h00, "R11 opcode cleared", opcode_o, 0);

        // R3: running cycle captures the data bus
        goto(0); data_i = 8'h3C;
        goto(2);
        chk(opcode_o == 8'h3C, "R3 running capture", opcode_o, 8'h3C);

        // R2: request that misses the end of T4 is ignored
        goto(1); halt_req = 1'b1;
        tick();  halt_req = 1'b0;
        goto(0);
        chk(halt_ack_o == 1'b0, "R2 short request ignored", halt_ack_o, 0);

        enter_halt();
        // R3: fetched byte discarded while halted
        data_i = 8'hA5;
        goto(2);
        chk(opcode_o == 8'h00, "R3 forced no-operation", opcode_o, 0);

        // R7: maskable request with enable clear has no effect
        goto(0); int_req = 1'b1;
        cycles(3);
        chk(halt_ack_o == 1'b1, "R7 masked request", halt_ack_o, 1);
        int_req = 1'b0;

        // R5: requests outside the sampling edge are missed
        set_ie(1'b1);
        goto(3); int_req = 1'b1;
        tick();  int_req = 1'b0;
        goto(3);
        chk(halt_ack_o == 1'b1, "R5 late pulse missed", halt_ack_o, 1);
        goto(0); int_req = 1'b1;
        goto(2); int_req = 1'b0;
        goto(0);
        chk(halt_ack_o == 1'b1, "R5 early pulse missed", halt_ack_o, 1);

        // R6: maskable exit
        goto(0); k = cyc; int_req = 1'b1;
        expect_ack(2'b10, k + 4);
        goto(3);
        chk(halt_ack_o == 1'b1, "R6 still halted in T4", halt_ack_o, 1);
        tick();
        chk(halt_ack_o == 1'b0 && ack_start_o == 1'b1, "R6 exit edge",
            {halt_ack_o, ack_start_o}, 1);
        int_req = 1'b0;
        tick();
        chk(ack_start_o == 1'b0, "R6 one-clock pulse", ack_start_o, 0);

        // R10: maskable acknowledge keeps enable set
        enter_halt();
        goto(0); k = cyc; int_req = 1'b1;
        expect_ack(2'b10, k + 4);
        goto(3); tick();
        chk(halt_ack_o == 1'b0, "R10 enable kept after maskable", halt_ack_o, 0);
        int_req = 1'b0;

        // R8: one-clock non-maskable pulse is latched
        enter_halt();
        goto(0); k = cyc; nmi_req = 1'b1;
        tick();  nmi_req = 1'b0;
        expect_ack(2'b01, k + 4);
        goto(3); tick();
        chk(halt_ack_o == 1'b0, "R8 short pulse latched", halt_ack_o, 0);

        // R10: non-maskable acknowledge cleared enable
        enter_halt();
        int_req = 1'b1;
        cycles(3);
        chk(halt_ack_o == 1'b1, "R10 enable cleared by non-maskable", halt_ack_o, 1);
        int_req = 1'b0;

        // R8: held line gives one acknowledge, pending cleared
        goto(0); k = cyc; nmi_req = 1'b1;
        expect_ack(2'b01, k + 4);
        goto(3); tick();
        chk(halt_ack_o == 1'b0, "R8 held line acknowledged", halt_ack_o, 0);
        enter_halt();
        cycles(3);
        chk(halt_ack_o == 1'b1, "R8 no second acknowledge", halt_ack_o, 1);
        nmi_req = 1'b0;

        // R9: both kinds at one sample
        set_ie(1'b1);
        goto(0); k = cyc; int_req = 1'b1; nmi_req = 1'b1;
        tick();  nmi_req = 1'b0;
        expect_ack(2'b01, k + 4);
        goto(3); tick();
        chk(halt_ack_o == 1'b0, "R9 exit on both", halt_ack_o, 0);
        enter_halt();
        cycles(2);
        chk(halt_ack_o == 1'b1, "R9 maskable blocked afterwards", halt_ack_o, 1);
        int_req = 1'b0;

        // R4: run past the refresh wrap (monitor checks each T3/T4)
        cycles(130);
        goto(2);
        chk(addr_o[15:7] == 9'd0 && addr_o[6:0] == exp_rf, "R4 after wrap",
            addr_o, {9'd0, exp_rf});

        // R11: reset in the middle of a halt with stale state
        set_ie(1'b1);
        goto(0); nmi_req = 1'b1;
        tick();  nmi_req = 1'b0;
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        chk(halt_ack_o == 1'b0 && fetch_o == 1'b1 && addr_o == PC_VAL,
            "R11 reset mid-halt", {halt_ack_o, fetch_o}, 1);
        goto(2);
        chk(addr_o == 16'h0000, "R11 refresh restarts", addr_o, 0);
        enter_halt();
        int_req = 1'b1;
        cycles(3);
        chk(halt_ack_o == 1'b1, "R11 enable and pending cleared", halt_ack_o, 1);
        int_req = 1'b0;

        cycles(1);
        chk(expq.size() == 0, "R6 all acknowledges seen", expq.size(), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule